// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides where each operand of an in-order five-stage integer pipeline is taken from when an earlier instruction has not yet written its result to the register file. It compares the source register numbers of the consumers with the destination register numbers and write flags of the two instructions ahead of them. The first of those instructions is in the memory stage and the second is in write-back. The block then produces mux select codes. The block is purely combinational and holds no state. The register file, the ALU, the muxes and stall generation sit outside it.

There are three kinds of consumer, and each has its own select outputs. The two ALU operand muxes in EX each get a two-bit code. The equality comparator for branches resolved in decode gets a one-bit select per operand. That select can only pick the memory-stage result, because a write-back result reaches decode through the register file, which writes in the first half of the cycle and is read in the second. The store-data path into the memory stage gets a one-bit select. It lets a store that follows a load of the same register take the loaded value from write-back, so no stall is needed.

Top module: `fwd_unit`

## Requirements
- R1: Each ALU select is a two-bit code. 2'b00 selects the normal operand from the decode/execute register, 2'b10 selects the memory-stage (EX/MEM) result and 2'b01 selects the write-back (MEM/WB) result. The code 2'b11 is never produced.
- R2: A stage forwards to an ALU operand only when its write flag is 1 and its destination number equals that operand's source number.
- R3: No path forwards a destination numbered 0. This covers the ALU selects, the compare selects and the store select.
- R4: When the memory-stage and write-back instructions both qualify for the same ALU operand, the select is 2'b10. The select is 2'b01 only when the memory stage does not qualify.
- R5: ALU operand A (compared with `ex_src_a`) and operand B (compared with `ex_src_b`) are resolved independently, so they can carry different codes in the same cycle.
- R6: `cmp_sel_a` (or `cmp_sel_b`) is 1 exactly when `id_is_branch` is 1, `em_wr` is 1, `em_dst` is nonzero and `em_dst` equals `id_src_a` (or `id_src_b`).
- R7: A write-back match alone never sets a compare select.
- R8: `st_data_sel` is 1 exactly when `mem_is_store` is 1, `mw_wr` is 1, `mw_dst` is nonzero and `mw_dst` equals `mem_store_src`.
- R9: When no condition holds, every select is at its non-forwarding value (2'b00 or 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the instruction in EX |
| ex_src_b | input | 5 | Second source register number of the instruction in EX |
| em_dst | input | 5 | Destination register number held in EX/MEM |
| em_wr | input | 1 | Register-write flag held in EX/MEM |
| mw_dst | input | 5 | Destination register number held in MEM/WB |
| mw_wr | input | 1 | Register-write flag held in MEM/WB |
| id_is_branch | input | 1 | The instruction in decode is a branch compared in decode |
| id_src_a | input | 5 | First compare source register number in decode |
| id_src_b | input | 5 | Second compare source register number in decode |
| mem_is_store | input | 1 | The instruction in the memory stage is a store |
| mem_store_src | input | 5 | Register number of the data the store writes to memory |
| alu_sel_a | output | 2 | Select code for ALU operand A |
| alu_sel_b | output | 2 | Select code for ALU operand B |
| cmp_sel_a | output | 1 | Bypass select for compare operand A |
| cmp_sel_b | output | 1 | Bypass select for compare operand B |
| st_data_sel | output | 1 | Bypass select for the store data |

## Verification
The memory-stage match and the write-back match can both qualify for the same operand in one cycle. Vectors give both stages the same destination and source, and a correct result keeps the 2'b10 code. Vectors where the memory stage matches but does not write, and a sweep over every register number with both stages matching, check that write-back is chosen only when the memory stage falls out and that register zero never forwards. Other vectors load the two ALU operands with different winners, or set a branch or store consumer at the same time as an ALU match, to show that each output is judged on its own.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_MW   = 2'b01,
    FWD_EM   = 2'b10
  } alu_sel_e;
endpackage

// File: rtl/fwd_alu_sel.sv
module fwd_alu_sel
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] em_dst,
  input  logic             em_wr,
  input  logic [REG_W-1:0] mw_dst,
  input  logic             mw_wr,
  output alu_sel_e         sel
);
  logic em_hit;
  logic mw_hit;

  always_comb begin
    em_hit = em_wr && (em_dst != '0) && (em_dst == src);
    mw_hit = mw_wr && (mw_dst != '0) && (mw_dst == src);
    if (em_hit)      sel = FWD_EM;
    else if (mw_hit) sel = FWD_MW;
    else             sel = FWD_NONE;
  end

  always_comb begin
    p_legal_code_r1: assert (sel != alu_sel_e'(2'b11));
    p_zero_src_r3: assert (!((src == '0) && (sel != FWD_NONE)));
    p_newer_wins_r4: assert (!(em_wr && (em_dst == src) && (src != '0) && (sel != FWD_EM)));
  end
endmodule

// File: rtl/fwd_cmp_sel.sv
module fwd_cmp_sel #(
  parameter int REG_W = 5
) (
  input  logic             is_branch,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] em_dst,
  input  logic             em_wr,
  output logic             sel
);
  always_comb begin
    sel = is_branch && em_wr && (em_dst != '0) && (em_dst == src);
  end

  always_comb begin
    p_only_branch_r6: assert (is_branch || !sel);
    p_needs_em_r7: assert (em_wr || !sel);
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int REG_W = 5
) (
  input  logic             is_store,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mw_dst,
  input  logic             mw_wr,
  output logic             sel
);
  always_comb begin
    sel = is_store && mw_wr && (mw_dst != '0) && (mw_dst == src);
  end

  always_comb begin
    p_only_store_r8: assert (is_store || !sel);
    p_store_zero_r3: assert (!((src == '0) && sel));
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] em_dst,
  input  logic             em_wr,
  input  logic [REG_W-1:0] mw_dst,
  input  logic             mw_wr,
  input  logic             id_is_branch,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] mem_store_src,
  output logic [1:0]       alu_sel_a,
  output logic [1:0]       alu_sel_b,
  output logic             cmp_sel_a,
  output logic             cmp_sel_b,
  output logic             st_data_sel
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] ex_src [NUM_OPS];
  logic [REG_W-1:0] id_src [NUM_OPS];
  alu_sel_e         alu_sel [NUM_OPS];
  logic             cmp_sel [NUM_OPS];

  assign ex_src[0] = ex_src_a;
  assign ex_src[1] = ex_src_b;
  assign id_src[0] = id_src_a;
  assign id_src[1] = id_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_alu_sel #(.REG_W(REG_W)) u_alu (
      .src   (ex_src[g]),
      .em_dst(em_dst),
      .em_wr (em_wr),
      .mw_dst(mw_dst),
      .mw_wr (mw_wr),
      .sel   (alu_sel[g])
    );
    fwd_cmp_sel #(.REG_W(REG_W)) u_cmp (
      .is_branch(id_is_branch),
      .src      (id_src[g]),
      .em_dst   (em_dst),
      .em_wr    (em_wr),
      .sel      (cmp_sel[g])
    );
  end

  fwd_store_sel #(.REG_W(REG_W)) u_st (
    .is_store(mem_is_store),
    .src     (mem_store_src),
    .mw_dst  (mw_dst),
    .mw_wr   (mw_wr),
    .sel     (st_data_sel)
  );

  assign alu_sel_a = alu_sel[0];
  assign alu_sel_b = alu_sel[1];
  assign cmp_sel_a = cmp_sel[0];
  assign cmp_sel_b = cmp_sel[1];

  always_comb begin
    p_quiet_r9: assert (em_wr || mw_wr || ((alu_sel_a == 2'b00) && (alu_sel_b == 2'b00)
                        && !cmp_sel_a && !cmp_sel_b && !st_data_sel));
  end
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] ex_src_a, ex_src_b, em_dst, mw_dst, id_src_a, id_src_b, mem_store_src;
  logic       em_wr, mw_wr, id_is_branch, mem_is_store;
  logic [1:0] alu_sel_a, alu_sel_b;
  logic       cmp_sel_a, cmp_sel_b, st_data_sel;

  fwd_unit u_fwd_unit (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .em_dst(em_dst), .em_wr(em_wr), .mw_dst(mw_dst), .mw_wr(mw_wr),
    .id_is_branch(id_is_branch), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .mem_is_store(mem_is_store), .mem_store_src(mem_store_src),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .cmp_sel_a(cmp_sel_a), .cmp_sel_b(cmp_sel_b), .st_data_sel(st_data_sel)
  );

  typedef struct packed {
    logic [4:0] sa; logic [4:0] sb; logic [4:0] emd; logic emw;
    logic [4:0] mwd; logic mww; logic br; logic [4:0] ia; logic [4:0] ib;
    logic st; logic [4:0] ss;
    logic [1:0] ea; logic [1:0] eb; logic ca; logic cb; logic sd;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R9 idle: nothing writes
    '{5'd0,5'd0,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,5'd0,1'b0,5'd0, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd9},
    // R2 memory stage writes r3, A reads r3
    '{5'd3,5'd4,5'd3,1'b1,5'd0,1'b0,1'b0,5'd0,5'd0,1'b0,5'd0, 2'b10,2'b00,1'b0,1'b0,1'b0, 8'd2},
    // R2 match without write flag
    '{5'd3,5'd3,5'd3,1'b0,5'd0,1'b0,1'b0,5'd0,5'd0,1'b0,5'd0, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd2},
    // R1 write-back code on B
    '{5'd1,5'd7,5'd0,1'b0,5'd7,1'b1,1'b0,5'd0,5'd0,1'b0,5'd0, 2'b00,2'b01,1'b0,1'b0,1'b0, 8'd1},
    // R4 both stages write r5
    '{5'd5,5'd5,5'd5,1'b1,5'd5,1'b1,1'b0,5'd0,5'd0,1'b0,5'd0, 2'b10,2'b10,1'b0,1'b0,1'b0, 8'd4},
    // R5 different winners on A and B
    '{5'd6,5'd5,5'd5,1'b1,5'd6,1'b1,1'b0,5'd0,5'd0,1'b0,5'd0, 2'b01,2'b10,1'b0,1'b0,1'b0, 8'd5},
    // R3 register zero everywhere
    '{5'd0,5'd0,5'd0,1'b1,5'd0,1'b1,1'b1,5'd0,5'd0,1'b1,5'd0, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd3},
    // R4 memory stage matches but does not write, write-back wins
    '{5'd9,5'd2,5'd9,1'b0,5'd9,1'b1,1'b0,5'd0,5'd0,1'b0,5'd0, 2'b01,2'b00,1'b0,1'b0,1'b0, 8'd4},
    // R6 branch compare A from memory stage, with ALU match too
    '{5'd12,5'd0,5'd12,1'b1,5'd0,1'b0,1'b1,5'd12,5'd13,1'b0,5'd0, 2'b10,2'b00,1'b1,1'b0,1'b0, 8'd6},
    // R6 not a branch
    '{5'd0,5'd0,5'd12,1'b1,5'd0,1'b0,1'b0,5'd12,5'd12,1'b0,5'd0, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd6},
    // R7 write-back match alone does not bypass to compare
    '{5'd0,5'd0,5'd0,1'b0,5'd12,1'b1,1'b1,5'd12,5'd12,1'b0,5'd0, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd7},
    // R8 store data from write-back
    '{5'd0,5'd0,5'd0,1'b0,5'd8,1'b1,1'b0,5'd0,5'd0,1'b1,5'd8, 2'b00,2'b00,1'b0,1'b0,1'b1, 8'd8},
    // R8 write-back not writing
    '{5'd0,5'd0,5'd0,1'b0,5'd8,1'b0,1'b0,5'd0,5'd0,1'b1,5'd8, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd8},
    // R8 not a store
    '{5'd0,5'd0,5'd0,1'b0,5'd8,1'b1,1'b0,5'd0,5'd0,1'b0,5'd8, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd8},
    // R6 compare B only, store bypass in the same cycle
    '{5'd0,5'd0,5'd20,1'b1,5'd21,1'b1,1'b1,5'd19,5'd20,1'b1,5'd21, 2'b00,2'b00,1'b0,1'b1,1'b1, 8'd6},
    // R3 compare with memory-stage destination zero
    '{5'd0,5'd0,5'd0,1'b1,5'd0,1'b0,1'b1,5'd0,5'd0,1'b0,5'd0, 2'b00,2'b00,1'b0,1'b0,1'b0, 8'd3}
  };

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string what, input int req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ex_src_a = v.sa; ex_src_b = v.sb; em_dst = v.emd; em_wr = v.emw;
    mw_dst = v.mwd; mw_wr = v.mww; id_is_branch = v.br; id_src_a = v.ia;
    id_src_b = v.ib; mem_is_store = v.st; mem_store_src = v.ss;
  endtask

  initial begin
    vec_t v;
    v = VEC[0];
    drive(v);
    @(negedge clk);
    #1;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk);
      drive(v);
      #1;
      chk("alu_sel_a", int'(v.req), alu_sel_a, v.ea);
      chk("alu_sel_b", int'(v.req), alu_sel_b, v.eb);
      chk("cmp_sel_a", int'(v.req), {1'b0, cmp_sel_a}, {1'b0, v.ca});
      chk("cmp_sel_b", int'(v.req), {1'b0, cmp_sel_b}, {1'b0, v.cb});
      chk("st_data_sel", int'(v.req), {1'b0, st_data_sel}, {1'b0, v.sd});
    end
    // R4 and R3 sweep: both stages write register r, both ALU sources read r
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      v = '0;
      v.sa = 5'(r); v.sb = 5'(r); v.emd = 5'(r); v.emw = 1'b1;
      v.mwd = 5'(r); v.mww = 1'b1;
      drive(v);
      #1;
      chk("sweep alu_sel_a", 4, alu_sel_a, (r == 0) ? 2'b00 : 2'b10);
      chk("sweep alu_sel_b", 3, alu_sel_b, (r == 0) ? 2'b00 : 2'b10);
    end
    // R9 back to idle after activity
    @(negedge clk);
    v = '0;
    drive(v);
    #1;
    chk("idle alu_sel_a", 9, alu_sel_a, 2'b00);
    chk("idle st_data_sel", 9, {1'b0, st_data_sel}, 2'b00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule